// File: doc/BRIEF.md
# Temperature-Indexed Setting Lookup Controller

This block picks two 8-bit position codes, one per variable resistor, from a pair of lookup tables addressed by temperature. A signed 16-bit temperature sample arrives with a valid strobe. Its upper byte holds whole degrees and its lower byte holds 1/256 °C. The block turns the sample into a step index with one step per 2 °C. It clamps the index at both ends and applies a 1 °C hysteresis on the way down, so a reading that hovers near a step edge does not make the index chatter.

The two tables are register arrays with a simple write port. The index selects one entry in each table, and the selected codes are registered onto the position outputs. Two override modes bypass parts of this path. With automatic indexing off, the index follows a manual index input. With temperature compensation off, the position outputs follow two manual position inputs. A disable pin and a disable control bit each force the resistors into high impedance. A registered status bit reports that state.

Top module: `temp_lut_ctrl`

## Requirements
- R1: After reset, the index output is 80h, both position outputs hold the table reset value (FFh by default, and every table entry resets to that value), and the high-impedance status is 0.
- R2: In automatic mode, the target step is k = floor((T + 40 °C) / 2 °C) for the two's-complement sample T. T is counted in units of 1/256 °C, so one step is 512 counts. The index is 80h + k, clamped to 80h for T at or below -40 °C and to C7h for T at or above +102 °C.
- R3: The index rises to the target step on the first valid sample that reaches that step. It falls only when the sample is at least 1 °C below the lower edge of the current step. It then lands on the step of T + 255/256 °C.
- R4: In automatic mode, the index changes only on a clock where the valid strobe is high. Samples without the strobe have no effect.
- R5: When the auto-index input is 0, the index loads the manual index on every clock. A manual value below 80h is clamped to 80h and a value above C7h is clamped to C7h.
- R6: With temperature compensation enabled, each position output shows its own table's entry at the current index, registered one clock after the index.
- R7: When the temperature-enable input is 0, position output 0 and position output 1 show manual position 0 and manual position 1 one clock later.
- R8: A table write stores tbl_data_i at index address tbl_addr_i (80h..C7h) in table tbl_sel_i (0 or 1). A write to an address outside 80h..C7h changes no entry.
- R9: hiz_en_o is high in the same cycle that the disable pin or the disable control bit is high.
- R10: hiz_sta_o shows, one clock later, whether the disable pin or the disable control bit was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_i | input | 16 | Two's-complement temperature, 1/256 °C per count |
| temp_vld_i | input | 1 | Temperature sample valid strobe |
| auto_idx_i | input | 1 | 1: index from temperature; 0: index from man_idx_i |
| man_idx_i | input | 8 | Manual index |
| tcomp_en_i | input | 1 | 1: positions from tables; 0: from manual positions |
| man_pos0_i | input | 8 | Manual position for resistor 0 |
| man_pos1_i | input | 8 | Manual position for resistor 1 |
| tbl_we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 1 | Table select for the write |
| tbl_addr_i | input | 8 | Write address in index space |
| tbl_data_i | input | 8 | Write data |
| hiz_pin_i | input | 1 | Disable pin |
| hiz_ctl_i | input | 1 | Disable control bit |
| idx_o | output | 8 | Current index |
| pos0_o | output | 8 | Position code for resistor 0 |
| pos1_o | output | 8 | Position code for resistor 1 |
| hiz_en_o | output | 1 | High-impedance enable for both resistors |
| hiz_sta_o | output | 1 | Registered high-impedance status |

## Verification
The bench walks the temperature through samples just inside and exactly at the 1 °C hysteresis edge, in both the low corner and the high corner. A design with the wrong comparison would step down one count too early or too late, or would fail to step down at all. It drives samples far beyond both clamp points, including the most negative and most positive codes. Wrong sign handling would wrap those samples to the opposite end of the table. It also targets samples that arrive without the strobe, manual indices outside the table range, and a write to an address outside the table. Broken gating would move the index, read a nonexistent entry, or corrupt an aliased entry. These show up as wrong index or wrong position values at the ports.

// File: rtl/temp_lut_pkg.sv
package temp_lut_pkg;
  localparam int TEMP_W    = 16;
  localparam int IDX_W     = 8;
  localparam int POS_W     = 8;
  localparam int N_ENTRY   = 72;
  localparam int STEP_W    = $clog2(N_ENTRY);
  localparam int CALC_W    = TEMP_W + 2;
  localparam int FRAC_BITS = 8;
  localparam int STEP_SH   = FRAC_BITS + 1;           // 2 degC per step
  localparam int LOW_DEG   = 40;                      // lowest edge at -40 degC
  localparam int HYST_OFS  = (1 << FRAC_BITS) - 1;    // just under 1 degC
  localparam logic [IDX_W-1:0] IDX_BASE = 8'h80;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_BASE + IDX_W'(N_ENTRY - 1);
  localparam logic signed [CALC_W-1:0] LOW_OFS = CALC_W'(LOW_DEG << FRAC_BITS);

  function automatic logic [STEP_W-1:0] step_of(input logic signed [CALC_W-1:0] d);
    logic signed [CALC_W-1:0] q;
    q = d >>> STEP_SH;
    if (d < 0)
      return '0;
    else if (q > CALC_W'(N_ENTRY - 1))
      return STEP_W'(N_ENTRY - 1);
    else
      return q[STEP_W-1:0];
  endfunction
endpackage

// File: rtl/temp_idx_tracker.sv
module temp_idx_tracker
  import temp_lut_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_vld_i,
  input  logic              auto_idx_i,
  input  logic [IDX_W-1:0]  man_idx_i,
  output logic [STEP_W-1:0] step_o
);
  logic signed [CALC_W-1:0] d_up;
  logic signed [CALC_W-1:0] d_dn;
  logic [STEP_W-1:0] up_step;
  logic [STEP_W-1:0] dn_step;
  logic [STEP_W-1:0] man_step;
  logic [IDX_W-1:0]  man_ofs;
  logic [STEP_W-1:0] step_d;
  logic [STEP_W-1:0] step_q;

  // distance above the lowest edge, in 1/256 degC
  always_comb begin
    d_up    = $signed({{(CALC_W-TEMP_W){temp_i[TEMP_W-1]}}, temp_i}) + LOW_OFS;
    d_dn    = d_up + CALC_W'(HYST_OFS);
    up_step = step_of(d_up);
    dn_step = step_of(d_dn);
  end

  always_comb begin
    man_ofs = man_idx_i - IDX_BASE;
    if (man_idx_i < IDX_BASE)
      man_step = '0;
    else if (man_idx_i > IDX_LAST)
      man_step = STEP_W'(N_ENTRY - 1);
    else
      man_step = man_ofs[STEP_W-1:0];
  end

  always_comb begin
    step_d = step_q;
    if (!auto_idx_i) begin
      step_d = man_step;
    end else if (temp_vld_i) begin
      if (up_step > step_q)
        step_d = up_step;
      else if (dn_step < step_q)
        step_d = dn_step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      step_q <= '0;
    else
      step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/setting_table.sv
module setting_table
  import temp_lut_pkg::*;
#(
  parameter logic [POS_W-1:0] RST_VAL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STEP_W-1:0] waddr_i,
  input  logic [POS_W-1:0]  wdata_i,
  input  logic [STEP_W-1:0] raddr_i,
  input  logic              use_tbl_i,
  input  logic [POS_W-1:0]  man_pos_i,
  output logic [POS_W-1:0]  pos_o
);
  logic [POS_W-1:0] mem_q [N_ENTRY];
  logic [POS_W-1:0] mem_d [N_ENTRY];
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] pos_q;

  always_comb begin
    for (int i = 0; i < N_ENTRY; i++) begin
      mem_d[i] = mem_q[i];
      if (we_i && (waddr_i == STEP_W'(i)))
        mem_d[i] = wdata_i;
    end
  end

  always_comb begin
    pos_d = use_tbl_i ? mem_q[raddr_i] : man_pos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRY; i++)
        mem_q[i] <= RST_VAL;
      pos_q <= RST_VAL;
    end else begin
      for (int i = 0; i < N_ENTRY; i++)
        mem_q[i] <= mem_d[i];
      pos_q <= pos_d;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/temp_lut_ctrl.sv
module temp_lut_ctrl
  import temp_lut_pkg::*;
#(
  parameter logic [POS_W-1:0] TBL_RST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_vld_i,
  input  logic              auto_idx_i,
  input  logic [IDX_W-1:0]  man_idx_i,
  input  logic              tcomp_en_i,
  input  logic [POS_W-1:0]  man_pos0_i,
  input  logic [POS_W-1:0]  man_pos1_i,
  input  logic              tbl_we_i,
  input  logic              tbl_sel_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [POS_W-1:0]  tbl_data_i,
  input  logic              hiz_pin_i,
  input  logic              hiz_ctl_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [POS_W-1:0]  pos0_o,
  output logic [POS_W-1:0]  pos1_o,
  output logic              hiz_en_o,
  output logic              hiz_sta_o
);
  localparam int N_RES = 2;

  logic [STEP_W-1:0] step;
  logic [IDX_W-1:0]  wofs;
  logic              waddr_ok;
  logic [POS_W-1:0]  man_pos [N_RES];
  logic [POS_W-1:0]  pos     [N_RES];
  logic              hiz_d;
  logic              hiz_q;

  temp_idx_tracker u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .temp_i     (temp_i),
    .temp_vld_i (temp_vld_i),
    .auto_idx_i (auto_idx_i),
    .man_idx_i  (man_idx_i),
    .step_o     (step)
  );

  assign idx_o    = IDX_BASE + IDX_W'(step);
  assign wofs     = tbl_addr_i - IDX_BASE;
  assign waddr_ok = (tbl_addr_i >= IDX_BASE) && (tbl_addr_i <= IDX_LAST);
  assign man_pos[0] = man_pos0_i;
  assign man_pos[1] = man_pos1_i;

  for (genvar r = 0; r < N_RES; r++) begin : g_res
    setting_table #(.RST_VAL(TBL_RST)) u_tbl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (tbl_we_i && waddr_ok && (tbl_sel_i == 1'(r))),
      .waddr_i   (wofs[STEP_W-1:0]),
      .wdata_i   (tbl_data_i),
      .raddr_i   (step),
      .use_tbl_i (tcomp_en_i),
      .man_pos_i (man_pos[r]),
      .pos_o     (pos[r])
    );
  end

  assign pos0_o = pos[0];
  assign pos1_o = pos[1];

  always_comb begin
    hiz_d = hiz_pin_i | hiz_ctl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      hiz_q <= 1'b0;
    else
      hiz_q <= hiz_d;
  end

  assign hiz_en_o  = hiz_d;
  assign hiz_sta_o = hiz_q;
endmodule

// File: rtl/temp_lut_ctrl_chk.sv
module temp_lut_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] temp_i,
  input logic        temp_vld_i,
  input logic        auto_idx_i,
  input logic [7:0]  man_idx_i,
  input logic        tcomp_en_i,
  input logic [7:0]  man_pos0_i,
  input logic [7:0]  man_pos1_i,
  input logic        tbl_we_i,
  input logic        tbl_sel_i,
  input logic [7:0]  tbl_addr_i,
  input logic [7:0]  tbl_data_i,
  input logic        hiz_pin_i,
  input logic        hiz_ctl_i,
  input logic [7:0]  idx_o,
  input logic [7:0]  pos0_o,
  input logic [7:0]  pos1_o,
  input logic        hiz_en_o,
  input logic        hiz_sta_o
);
  // R2
  cold_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_idx_i && temp_vld_i && ($signed(temp_i) <= -16'sd10240)) |=> (idx_o == 8'h80));

  // R4
  no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_idx_i && !temp_vld_i) |=> $stable(idx_o));

  // R5
  man_idx_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_idx_i && (man_idx_i >= 8'h80) && (man_idx_i <= 8'hC7)) |=> (idx_o == $past(man_idx_i)));

  // R7
  man_pos0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tcomp_en_i |=> (pos0_o == $past(man_pos0_i)));

  // R7
  man_pos1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tcomp_en_i |=> (pos1_o == $past(man_pos1_i)));

  // R10
  hiz_sta_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiz_pin_i || hiz_ctl_i) |=> hiz_sta_o);

  // R10
  hiz_sta_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hiz_pin_i || hiz_ctl_i) |=> !hiz_sta_o);
endmodule

bind temp_lut_ctrl temp_lut_ctrl_chk chk_i (.*);

// File: tb/temp_lut_ctrl_tb_top.sv
module temp_lut_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] temp_i;
  logic        temp_vld_i;
  logic        auto_idx_i;
  logic [7:0]  man_idx_i;
  logic        tcomp_en_i;
  logic [7:0]  man_pos0_i;
  logic [7:0]  man_pos1_i;
  logic        tbl_we_i;
  logic        tbl_sel_i;
  logic [7:0]  tbl_addr_i;
  logic [7:0]  tbl_data_i;
  logic        hiz_pin_i;
  logic        hiz_ctl_i;
  logic [7:0]  idx_o;
  logic [7:0]  pos0_o;
  logic [7:0]  pos1_o;
  logic        hiz_en_o;
  logic        hiz_sta_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  temp_lut_ctrl dut_i (.*);

  // {temperature sample, expected index}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {16'hCE00, 8'h80},  // -50 degC, low clamp        R2
    {16'hDA00, 8'h81},  // -38 degC, step up           R3
    {16'hD980, 8'h81},  // -38.5, inside band          R3
    {16'hD901, 8'h81},  // just under 1 degC below     R3
    {16'hD900, 8'h80},  // exactly 1 degC below        R3
    {16'h0000, 8'h94},  // 0 degC, jump up             R2
    {16'h1980, 8'hA0},  // 25.5 degC                   R2
    {16'h1780, 8'hA0},  // 23.5, inside band           R3
    {16'h16C0, 8'h9F},  // 22.75, step down            R3
    {16'h6600, 8'hC7},  // 102 degC                    R2
    {16'h7FFF, 8'hC7},  // max code, high clamp        R2
    {16'h6580, 8'hC7},  // 101.5, inside band          R3
    {16'h6480, 8'hC6},  // 100.5, step down            R3
    {16'h8000, 8'h80},  // -128 degC                   R2
    {16'hD800, 8'h80},  // -40 degC                    R2
    {16'hF600, 8'h8F}   // -10 degC                    R2
  };

  function automatic logic [7:0] t0_val(input logic [7:0] idx);
    return 8'(5 + 3 * (idx - 8'h80));
  endfunction
  function automatic logic [7:0] t1_val(input logic [7:0] idx);
    return 8'(8'hFF - 2 * (idx - 8'h80));
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_temp(input logic [15:0] t);
    temp_i     = t;
    temp_vld_i = 1'b1;
    tick();
    temp_vld_i = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] a, input logic [7:0] d);
    tbl_we_i   = 1'b1;
    tbl_sel_i  = sel;
    tbl_addr_i = a;
    tbl_data_i = d;
    tick();
    tbl_we_i = 1'b0;
  endtask

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    temp_i = '0; temp_vld_i = 1'b0; auto_idx_i = 1'b1; man_idx_i = 8'h80;
    tcomp_en_i = 1'b1; man_pos0_i = '0; man_pos1_i = '0;
    tbl_we_i = 1'b0; tbl_sel_i = 1'b0; tbl_addr_i = '0; tbl_data_i = '0;
    hiz_pin_i = 1'b0; hiz_ctl_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk("R1 idx", idx_o, 8'h80);
    chk("R1 pos0", pos0_o, 8'hFF);
    chk("R1 pos1", pos1_o, 8'hFF);
    chk("R1 sta", {7'd0, hiz_sta_o}, 8'h00);

    // R8 load both tables
    for (int k = 0; k < 72; k++) begin
      wr(1'b0, 8'(8'h80 + k), t0_val(8'(8'h80 + k)));
      wr(1'b1, 8'(8'h80 + k), t1_val(8'(8'h80 + k)));
    end
    tick();
    chk("R8 pos0 after load", pos0_o, t0_val(8'h80));
    chk("R8 pos1 after load", pos1_o, t1_val(8'h80));

    // R2 R3 R6 vector walk
    for (int v = 0; v < NV; v++) begin
      apply_temp(VEC[v][23:8]);
      chk("R2/R3 idx", idx_o, VEC[v][7:0]);
      tick();
      chk("R6 pos0", pos0_o, t0_val(VEC[v][7:0]));
      chk("R6 pos1", pos1_o, t1_val(VEC[v][7:0]));
    end

    // R4 sample without strobe is ignored
    temp_i = 16'h6600;
    tick(); tick();
    chk("R4 no strobe", idx_o, 8'h8F);

    // R7 manual positions
    man_pos0_i = 8'h3C; man_pos1_i = 8'hC3; tcomp_en_i = 1'b0;
    tick();
    chk("R7 pos0", pos0_o, 8'h3C);
    chk("R7 pos1", pos1_o, 8'hC3);
    tcomp_en_i = 1'b1;
    tick();
    chk("R7 back to table", pos0_o, t0_val(8'h8F));

    // R5 manual index, in range and clamped
    auto_idx_i = 1'b0; man_idx_i = 8'hB0;
    tick();
    chk("R5 idx", idx_o, 8'hB0);
    tick();
    chk("R5 R6 pos0", pos0_o, t0_val(8'hB0));
    man_idx_i = 8'h10;
    tick();
    chk("R5 low clamp", idx_o, 8'h80);
    man_idx_i = 8'hF0;
    tick();
    chk("R5 high clamp", idx_o, 8'hC7);
    temp_i = 16'hD800; temp_vld_i = 1'b1;
    tick();
    temp_vld_i = 1'b0;
    chk("R5 temp ignored", idx_o, 8'hC7);

    // R8 out-of-range write must not alias onto entry at A0h
    wr(1'b0, 8'h20, 8'h11);
    wr(1'b1, 8'hE0, 8'h22);
    man_idx_i = 8'hA0;
    tick(); tick();
    chk("R8 no alias t0", pos0_o, t0_val(8'hA0));
    chk("R8 no alias t1", pos1_o, t1_val(8'hA0));
    // R8 in-range write seen at current index
    wr(1'b1, 8'hA0, 8'h5A);
    tick();
    chk("R8 write t1", pos1_o, 8'h5A);
    chk("R8 t0 untouched", pos0_o, t0_val(8'hA0));

    // R9 R10 disable
    hiz_pin_i = 1'b1;
    #1;
    chk("R9 pin", {7'd0, hiz_en_o}, 8'h01);
    chk("R10 sta before edge", {7'd0, hiz_sta_o}, 8'h00);
    tick();
    chk("R10 sta pin", {7'd0, hiz_sta_o}, 8'h01);
    hiz_pin_i = 1'b0; hiz_ctl_i = 1'b1;
    #1;
    chk("R9 ctl", {7'd0, hiz_en_o}, 8'h01);
    tick();
    chk("R10 sta ctl", {7'd0, hiz_sta_o}, 8'h01);
    hiz_ctl_i = 1'b0;
    #1;
    chk("R9 off", {7'd0, hiz_en_o}, 8'h00);
    tick();
    chk("R10 sta off", {7'd0, hiz_sta_o}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule